// File: doc/BRIEF.md
# Segment Relocation and Limit Checker

This block turns program-relative addresses into physical addresses for a small processor without paging. It keeps two segments, one for instruction fetch and one for loads and stores. Each segment has a base, which is added to the program-relative address, and a limit, against which that address is checked before anything is sent toward memory.

The data path forms its program-relative address from a register value plus an offset. It folds the segment base into that same sum with a three-operand carry-save stage followed by a single carry-propagate adder, so relocation costs little more than the address add itself. The fetch path adds its base to the program counter directly.

Supervisor software programs the four registers through a write port that is gated by a privilege input. Each access channel has a valid/ready request side and a registered valid/ready response that carries either a physical address or a fault flag.

Top module: `seg_reloc_unit`

## Requirements
- R1: An active-low synchronous reset clears both bases and both limits to zero and empties both response stages. Until a limit is programmed, every accepted access returns a fault.
- R2: A legal fetch returns physical address = (fetch base + program counter) modulo 2^PA_W.
- R3: The data program-relative address is the full LA_W+1-bit sum of register value and offset, with no wrap. A legal data access returns (data base + that sum) modulo 2^PA_W.
- R4: An access is legal only when its program-relative address is strictly below its segment limit; an address equal to the limit faults. A fault response has the fault bit at 1 and physical address 0, so it is never a memory request. A memory request is a response with valid at 1 and fault at 0.
- R5: Fetches are checked and relocated only with the fetch pair, and data accesses only with the data pair.
- R6: When cfg_we and cfg_priv are both 1, the register chosen by cfg_sel is written: 0 fetch base, 1 fetch limit, 2 data base, 3 data limit. A base takes cfg_wdata[PA_W-1:0] and a limit takes cfg_wdata[LA_W:0]. The new value applies from the next cycle; an access accepted in the same cycle as the write uses the old value.
- R7: A write with cfg_priv at 0 changes no register.
- R8: On each channel a request is accepted when valid and ready are both 1. Ready equals (no response pending) or (response ready). The response appears the cycle after acceptance and is held unchanged while the response side is not ready.
- R9: The data write flag of a request returns unchanged on the data response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_priv | input | 1 | Writer is in supervisor mode |
| cfg_sel | input | 2 | Register select (0 fetch base, 1 fetch limit, 2 data base, 3 data limit) |
| cfg_wdata | input | PA_W | Write value |
| f_req_valid | input | 1 | Fetch request valid |
| f_req_ready | output | 1 | Fetch request accepted |
| f_req_pc | input | LA_W | Fetch program counter |
| f_rsp_valid | output | 1 | Fetch response valid |
| f_rsp_ready | input | 1 | Fetch response consumed |
| f_rsp_paddr | output | PA_W | Fetch physical address (0 on fault) |
| f_rsp_fault | output | 1 | Fetch limit violation |
| d_req_valid | input | 1 | Data request valid |
| d_req_ready | output | 1 | Data request accepted |
| d_req_rbase | input | LA_W | Register operand of the address |
| d_req_offs | input | LA_W | Offset operand of the address |
| d_req_wr | input | 1 | Access is a store |
| d_rsp_valid | output | 1 | Data response valid |
| d_rsp_ready | input | 1 | Data response consumed |
| d_rsp_paddr | output | PA_W | Data physical address (0 on fault) |
| d_rsp_fault | output | 1 | Data limit violation |
| d_rsp_wr | output | 1 | Store flag of the response |

## Verification
The bench builds the block with its defaults, LA_W = 12 and PA_W = 16. The 13-bit limit can then exceed 2^12, so a data sum that carries out of 12 bits can be tested as legal and relocated by its full value. With a 16-bit physical space, a small base near the top of memory is enough to show the physical address wrapping. Both widths are small enough that exact boundary values, including an address equal to the limit, are written directly in the bench.

// File: rtl/seg_reloc_pkg.sv
// Package: shared encodings for the segment relocation unit.
// Assumes a 2-bit register select on the configuration port.
package seg_reloc_pkg;

    // Register select codes of the supervisor write port.
    typedef enum logic [1:0] {
        SEL_FBASE = 2'd0,
        SEL_FLIM  = 2'd1,
        SEL_DBASE = 2'd2,
        SEL_DLIM  = 2'd3
    } cfg_sel_e;

    // Number of segments held (fetch, data).
    localparam int unsigned NUM_SEG = 2;

endpackage

// File: rtl/seg_regfile.sv
// Module: base/limit register file for the fetch (index 0) and data
// (index 1) segments. Writes are accepted only with the privilege bit
// set and become visible the cycle after the write.
// Assumes PA_W >= LA_W + 1.
module seg_regfile
    import seg_reloc_pkg::*;
#(
    parameter int unsigned LA_W = 12,
    parameter int unsigned PA_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic                cfg_priv,
    input  logic [1:0]          cfg_sel,
    input  logic [PA_W-1:0]     cfg_wdata,
    output logic [PA_W-1:0]     fbase,
    output logic [LA_W:0]       flim,
    output logic [PA_W-1:0]     dbase,
    output logic [LA_W:0]       dlim
);
    localparam int unsigned LIM_W = LA_W + 1;

    logic [NUM_SEG-1:0][PA_W-1:0]  base_q;
    logic [NUM_SEG-1:0][LIM_W-1:0] lim_q;
    logic                          wr_ok;

    // Purpose: qualify a write with the supervisor bit.
    assign wr_ok = cfg_we && cfg_priv;

    for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
        localparam logic [1:0] BASE_CODE = 2'(2 * s);
        localparam logic [1:0] LIM_CODE  = 2'(2 * s + 1);

        // Purpose: hold the base of segment s.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_q[s] <= '0;
            end else if (wr_ok && (cfg_sel == BASE_CODE)) begin
                base_q[s] <= cfg_wdata;
            end
        end

        // Purpose: hold the limit of segment s.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lim_q[s] <= '0;
            end else if (wr_ok && (cfg_sel == LIM_CODE)) begin
                lim_q[s] <= cfg_wdata[LIM_W-1:0];
            end
        end
    end

    // Purpose: present registers by segment role.
    assign fbase = base_q[0];
    assign flim  = lim_q[0];
    assign dbase = base_q[1];
    assign dlim  = lim_q[1];

    AST_UNPRIV_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_priv) |=> ($stable(base_q) && $stable(lim_q))); // R7

    AST_FLIM_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_priv && cfg_sel == SEL_FLIM) |=> (flim == $past(cfg_wdata[LIM_W-1:0]))); // R6

endmodule

// File: rtl/csa3_add.sv
// Module: three-operand adder built as one carry-save level followed by
// a single carry-propagate add. The result wraps modulo 2^W.
module csa3_add #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] c,
    output logic [W-1:0] y
);
    logic [W-1:0] sum_v;
    logic [W-1:0] car_v;

    // Purpose: bitwise full-adder reduction of three operands into two.
    always_comb begin
        sum_v = a ^ b ^ c;
        car_v = ((a & b) | (a & c) | (b & c)) << 1;
    end

    // Purpose: final carry-propagate add.
    assign y = sum_v + car_v;

endmodule

// File: rtl/reloc_lane.sv
// Module: one access channel. It forms the program-relative address,
// checks it against the segment limit, relocates it by the base and
// registers the result in a one-entry valid/ready response stage.
// USE_OFFSET=1 adds two operands with the carry-save path; with 0 only
// operand A is used. Assumes PA_W >= LA_W + 1.
module reloc_lane #(
    parameter int unsigned LA_W       = 12,
    parameter int unsigned PA_W       = 16,
    parameter bit          USE_OFFSET = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic [LA_W-1:0] in_opa,
    input  logic [LA_W-1:0] in_opb,
    input  logic            in_wr,
    input  logic [PA_W-1:0] base,
    input  logic [LA_W:0]   lim,
    output logic            out_valid,
    input  logic            out_ready,
    output logic [PA_W-1:0] out_paddr,
    output logic            out_fault,
    output logic            out_wr
);
    localparam int unsigned LOG_W = LA_W + 1;
    localparam int unsigned PAD_W = PA_W - LA_W;

    logic [LOG_W-1:0] laddr;
    logic [PA_W-1:0]  paddr;
    logic             legal;
    logic             accept;

    if (USE_OFFSET) begin : g_offs
        logic [PA_W-1:0] opa_x;
        logic [PA_W-1:0] opb_x;

        // Purpose: zero-extend the operands to the physical width.
        assign opa_x = {{PAD_W{1'b0}}, in_opa};
        assign opb_x = {{PAD_W{1'b0}}, in_opb};

        // Purpose: full-width program-relative sum for the limit check.
        assign laddr = {1'b0, in_opa} + {1'b0, in_opb};

        csa3_add #(.W(PA_W)) u_csa (
            .a (base),
            .b (opa_x),
            .c (opb_x),
            .y (paddr)
        );
    end else begin : g_plain
        logic unused_opb;

        // Purpose: mark the absent second operand as intentionally unused.
        assign unused_opb = ^in_opb;

        // Purpose: program-relative address is operand A alone.
        assign laddr = {1'b0, in_opa};

        // Purpose: relocate by a two-input add.
        assign paddr = base + {{PAD_W{1'b0}}, in_opa};
    end

    // Purpose: strict-below limit test.
    assign legal = (laddr < lim);

    // Purpose: one-entry stage handshake.
    assign in_ready = !out_valid || out_ready;
    assign accept   = in_valid && in_ready;

    // Purpose: register the response of an accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_paddr <= '0;
            out_fault <= 1'b0;
            out_wr    <= 1'b0;
        end else if (in_ready) begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_fault <= !legal;
                out_paddr <= legal ? paddr : '0;
                out_wr    <= in_wr;
            end
        end
    end

    AST_ZERO_LIM_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && lim == '0) |=> (out_valid && out_fault)); // R1

    AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_fault) |-> (out_paddr == '0)); // R4

    AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_paddr) && $stable(out_fault))); // R8

    AST_EMPTY_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_valid) |-> in_ready); // R8

    AST_WR_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (out_wr == $past(in_wr))); // R9

endmodule

// File: rtl/seg_reloc_unit.sv
// Module: top of the segment relocation unit. A fetch channel uses the
// fetch base/limit, a data channel the data base/limit; both are fed by a
// privileged register file. Assumes PA_W >= LA_W + 1.
module seg_reloc_unit
    import seg_reloc_pkg::*;
#(
    parameter int unsigned LA_W = 12,
    parameter int unsigned PA_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic            cfg_priv,
    input  logic [1:0]      cfg_sel,
    input  logic [PA_W-1:0] cfg_wdata,
    input  logic            f_req_valid,
    output logic            f_req_ready,
    input  logic [LA_W-1:0] f_req_pc,
    output logic            f_rsp_valid,
    input  logic            f_rsp_ready,
    output logic [PA_W-1:0] f_rsp_paddr,
    output logic            f_rsp_fault,
    input  logic            d_req_valid,
    output logic            d_req_ready,
    input  logic [LA_W-1:0] d_req_rbase,
    input  logic [LA_W-1:0] d_req_offs,
    input  logic            d_req_wr,
    output logic            d_rsp_valid,
    input  logic            d_rsp_ready,
    output logic [PA_W-1:0] d_rsp_paddr,
    output logic            d_rsp_fault,
    output logic            d_rsp_wr
);
    logic [PA_W-1:0] fbase;
    logic [PA_W-1:0] dbase;
    logic [LA_W:0]   flim;
    logic [LA_W:0]   dlim;
    logic            unused_f_wr;

    seg_regfile #(.LA_W(LA_W), .PA_W(PA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_priv  (cfg_priv),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .fbase     (fbase),
        .flim      (flim),
        .dbase     (dbase),
        .dlim      (dlim)
    );

    reloc_lane #(.LA_W(LA_W), .PA_W(PA_W), .USE_OFFSET(1'b0)) u_fetch (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (f_req_valid),
        .in_ready  (f_req_ready),
        .in_opa    (f_req_pc),
        .in_opb    ('0),
        .in_wr     (1'b0),
        .base      (fbase),
        .lim       (flim),
        .out_valid (f_rsp_valid),
        .out_ready (f_rsp_ready),
        .out_paddr (f_rsp_paddr),
        .out_fault (f_rsp_fault),
        .out_wr    (unused_f_wr)
    );

    reloc_lane #(.LA_W(LA_W), .PA_W(PA_W), .USE_OFFSET(1'b1)) u_data (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (d_req_valid),
        .in_ready  (d_req_ready),
        .in_opa    (d_req_rbase),
        .in_opb    (d_req_offs),
        .in_wr     (d_req_wr),
        .base      (dbase),
        .lim       (dlim),
        .out_valid (d_rsp_valid),
        .out_ready (d_rsp_ready),
        .out_paddr (d_rsp_paddr),
        .out_fault (d_rsp_fault),
        .out_wr    (d_rsp_wr)
    );

    AST_FETCH_IGNORES_DATA_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (f_req_valid && f_req_ready && {1'b0, f_req_pc} >= flim) |=> f_rsp_fault); // R5

endmodule

// File: tb/seg_reloc_unit_tb_top.sv
`timescale 1ns/100ps
module seg_reloc_unit_tb_top;
    localparam int unsigned LA_W = 12;
    localparam int unsigned PA_W = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cfg_we = 1'b0, cfg_priv = 1'b0;
    logic [1:0]      cfg_sel = '0;
    logic [PA_W-1:0] cfg_wdata = '0;
    logic            f_req_valid = 1'b0, f_req_ready;
    logic [LA_W-1:0] f_req_pc = '0;
    logic            f_rsp_valid, f_rsp_ready = 1'b1, f_rsp_fault;
    logic [PA_W-1:0] f_rsp_paddr;
    logic            d_req_valid = 1'b0, d_req_ready, d_req_wr = 1'b0;
    logic [LA_W-1:0] d_req_rbase = '0, d_req_offs = '0;
    logic            d_rsp_valid, d_rsp_ready = 1'b1, d_rsp_fault, d_rsp_wr;
    logic [PA_W-1:0] d_rsp_paddr;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    seg_reloc_unit #(.LA_W(LA_W), .PA_W(PA_W)) dut_i (.*);

    task automatic check(input string req, input string what,
                         input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [PA_W-1:0] val, input logic priv);
        @(negedge clk);
        cfg_we = 1'b1; cfg_priv = priv; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0; cfg_priv = 1'b0;
    endtask

    // One fetch; response sampled at the following negedge.
    task automatic fetch_chk(input string req, input logic [LA_W-1:0] pc,
                             input logic exp_fault, input logic [PA_W-1:0] exp_pa);
        @(negedge clk);
        f_req_valid = 1'b1; f_req_pc = pc;
        @(negedge clk);
        f_req_valid = 1'b0;
        check(req, "fetch valid", f_rsp_valid, 1);
        check(req, "fetch fault", f_rsp_fault, exp_fault);
        check(req, "fetch paddr", f_rsp_paddr, exp_fault ? 0 : exp_pa);
    endtask

    task automatic data_chk(input string req, input logic [LA_W-1:0] rb, input logic [LA_W-1:0] of,
                            input logic wr, input logic exp_fault, input logic [PA_W-1:0] exp_pa);
        @(negedge clk);
        d_req_valid = 1'b1; d_req_rbase = rb; d_req_offs = of; d_req_wr = wr;
        @(negedge clk);
        d_req_valid = 1'b0;
        check(req, "data valid", d_rsp_valid, 1);
        check(req, "data fault", d_rsp_fault, exp_fault);
        check(req, "data paddr", d_rsp_paddr, exp_fault ? 0 : exp_pa);
        check(req, "data wr", d_rsp_wr, wr);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R1", "fetch rsp empty", f_rsp_valid, 0);
        check("R8", "fetch ready when empty", f_req_ready, 1);
        check("R1", "data rsp empty", d_rsp_valid, 0);
        fetch_chk("R1", 12'h000, 1'b1, 0);
        data_chk("R1", 12'h000, 12'h000, 1'b0, 1'b1, 0);
    endtask

    task automatic t_program();
        cfg_write(2'd0, 16'h1000, 1'b1);
        cfg_write(2'd1, 16'h0100, 1'b1);
        cfg_write(2'd2, 16'h8000, 1'b1);
        cfg_write(2'd3, 16'h0200, 1'b1);
    endtask

    task automatic t_fetch();
        fetch_chk("R2", 12'h010, 1'b0, 16'h1010);
        fetch_chk("R4", 12'h0FF, 1'b0, 16'h10FF);
        fetch_chk("R4", 12'h100, 1'b1, 0);
    endtask

    task automatic t_data();
        data_chk("R3", 12'h040, 12'h030, 1'b0, 1'b0, 16'h8070);
        data_chk("R9", 12'h100, 12'h0FF, 1'b1, 1'b0, 16'h81FF);
        data_chk("R4", 12'h100, 12'h100, 1'b1, 1'b1, 0);
        data_chk("R3", 12'hFFF, 12'hFFF, 1'b0, 1'b1, 0);
        cfg_write(2'd3, 16'h1FFF, 1'b1);
        data_chk("R3", 12'hFFF, 12'hFFF, 1'b0, 1'b0, 16'h9FFE);
    endtask

    task automatic t_separate();
        fetch_chk("R5", 12'h150, 1'b1, 0);
        data_chk("R5", 12'h150, 12'h000, 1'b0, 1'b0, 16'h8150);
    endtask

    task automatic t_wrap();
        cfg_write(2'd2, 16'hF000, 1'b1);
        data_chk("R3", 12'hFFF, 12'hFFF, 1'b0, 1'b0, 16'h0FFE);
    endtask

    task automatic t_same_cycle();
        @(negedge clk);
        cfg_we = 1'b1; cfg_priv = 1'b1; cfg_sel = 2'd1; cfg_wdata = 16'h0020;
        f_req_valid = 1'b1; f_req_pc = 12'h050;
        @(negedge clk);
        cfg_we = 1'b0; cfg_priv = 1'b0; f_req_valid = 1'b0;
        check("R6", "same-cycle fetch fault", f_rsp_fault, 0);
        check("R6", "same-cycle fetch paddr", f_rsp_paddr, 16'h1050);
        fetch_chk("R6", 12'h050, 1'b1, 0);
    endtask

    task automatic t_unpriv();
        cfg_write(2'd1, 16'h0FFF, 1'b0);
        fetch_chk("R7", 12'h050, 1'b1, 0);
        cfg_write(2'd0, 16'h2000, 1'b0);
        fetch_chk("R7", 12'h010, 1'b0, 16'h1010);
    endtask

    task automatic t_backpressure();
        @(negedge clk);
        f_rsp_ready = 1'b0;
        f_req_valid = 1'b1; f_req_pc = 12'h010;
        @(negedge clk);
        f_req_valid = 1'b0;
        check("R8", "bp valid", f_rsp_valid, 1);
        check("R8", "bp ready low", f_req_ready, 0);
        check("R8", "bp paddr", f_rsp_paddr, 16'h1010);
        f_req_valid = 1'b1; f_req_pc = 12'h011;
        @(negedge clk);
        check("R8", "bp held paddr", f_rsp_paddr, 16'h1010);
        check("R8", "bp held valid", f_rsp_valid, 1);
        f_rsp_ready = 1'b1;
        @(negedge clk);
        f_req_valid = 1'b0;
        check("R8", "bp next paddr", f_rsp_paddr, 16'h1011);
        @(negedge clk);
        check("R8", "bp drained", f_rsp_valid, 0);
    endtask

    initial begin
        t_reset();
        t_program();
        t_fetch();
        t_data();
        t_separate();
        t_wrap();
        t_same_cycle();
        t_unpriv();
        t_backpressure();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule